// File: doc/BRIEF.md
# Linear Speed Reference Ramp Limiter

This block sits between a stepped digital speed setpoint and the voltage and frequency demand paths of a volts-per-hertz motor drive. Whatever the setpoint does, the reference it produces travels toward it in a straight line. The rise rate and the fall rate are set independently. The result is that the motor's voltage and frequency never jump, even when the operator moves the setpoint from zero to full scale in one step.

The ramp is held in a fixed-point accumulator that has fractional bits below the output word. On each tick of a programmable prescaler, the accumulator adds the rise step or subtracts the fall step, and then stops exactly on the target. A start request is latched. Until it is latched the effective target is zero, and a stop request clears the latch. Once running, the target never drops below a small floor code, so the inverter starts switching promptly even at a zero speed setting. An already-compared current-limit flag forces the target to zero while it is high. This pulls voltage and frequency down at the fall rate until the flag clears.

Top module: `spd_ramp_limiter`

## Requirements
- R1: A synchronous active-low reset sets `ref_out` to 0, clears the start latch and restarts the prescaler.
- R2: The start latch is set by a one-cycle `start_req` and cleared by `stop_req`. If both arrive in the same cycle, stop wins. While the latch is clear, the effective setpoint is 0, so `ref_out` ramps down to 0 and stays there whatever `setpoint` is.
- R3: While the latch is set, the effective setpoint is `max(setpoint, FLOOR)`, with FLOOR = 4 by default.
- R4: The accumulator carries FRAC = 8 fraction bits below `ref_out`. When it is below its target, each tick adds `accel_step` in units of 1/256 LSB, so `ref_out` never rises by more than `accel_step/256 + 1` between two cycles.
- R5: When above its target, each tick subtracts `decel_step` in the same units, independently of `accel_step`, so `ref_out` never falls by more than `decel_step/256 + 1` between two cycles.
- R6: The output stops exactly on the target with no overshoot, including when the distance is not a multiple of the step.
- R7: The direction of travel is decided only by whether the target is above or below the present accumulator value. The time to reach a target is the distance divided by the step, in ticks.
- R8: The prescaler gives one tick every `tick_div + 1` clock cycles, and the output changes only on a tick.
- R9: While `ilim_req` is 1, the target is 0 whatever the setpoint, so `ref_out` never rises and falls at the `decel_step` rate. When the flag clears, the ramp returns toward the effective setpoint.
- R10: `at_target` is 1 exactly when the accumulator, fraction included, equals the effective setpoint, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setpoint | input | W (12) | Requested speed word |
| start_req | input | 1 | One-cycle request to set the start latch |
| stop_req | input | 1 | One-cycle request to clear the start latch (dominant) |
| accel_step | input | RATE_W (12) | Rise increment per tick, in 1/256 LSB |
| decel_step | input | RATE_W (12) | Fall decrement per tick, in 1/256 LSB |
| tick_div | input | PRE_W (20) | Prescaler period minus one |
| ilim_req | input | 1 | Current-limit flag, already compared |
| ref_out | output | W (12) | Ramped speed reference |
| at_target | output | 1 | Output sits exactly on the effective setpoint |

## Verification
The bench drives distances that are not multiples of the step. A design that compared only integer parts, or clamped late, would overshoot the target or hover one code short with `at_target` never rising. It uses fractional fall steps with a rise step that differs from them, which exposes a design that shares one rate for both directions or truncates the fraction (the output would never move). It raises the current-limit flag while the setpoint sits far above the output, and a design that still obeyed the setpoint would keep climbing. It also checks the floor clamp at a zero setting, the dominant stop in the same cycle as a start, and the prescaler spacing, where a miscounted divider shows up as a ramp time off by whole tick periods.

// File: rtl/spd_ramp_pkg.sv
// Shared types for the speed reference ramp limiter.
package spd_ramp_pkg;
    // Direction the accumulator takes on the next tick.
    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_UP   = 2'd1,
        RAMP_DOWN = 2'd2
    } ramp_dir_e;
endpackage

// File: rtl/spd_ramp_tick.sv
// Prescaler: emits a one-cycle tick every (div + 1) clock cycles.
// Assumes div may change at any time; a count past a new smaller div wraps at once.
module spd_ramp_tick #(
    parameter int PRE_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] cnt;

    // Count cycles and flag the wrap as a registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/spd_ramp_setpt.sv
// Setpoint conditioner: holds the start latch and forms the effective setpoint,
// zero while stopped and never below FLOOR while running.
// Assumes start and stop requests are synchronous pulses; stop dominates.
module spd_ramp_setpt #(
    parameter int W     = 12,
    parameter int FLOOR = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_req,
    input  logic         stop_req,
    input  logic [W-1:0] setpoint,
    output logic         run_q,
    output logic [W-1:0] eff_sp
);
    localparam logic [W-1:0] FLOOR_CODE = W'(FLOOR);

    // Start latch with dominant stop.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= 1'b0;
        else if (stop_req)  run_q <= 1'b0;
        else if (start_req) run_q <= 1'b1;
    end

    // Effective setpoint: zero when stopped, floor-clamped when running.
    always_comb begin
        if (!run_q)                    eff_sp = '0;
        else if (setpoint < FLOOR_CODE) eff_sp = FLOOR_CODE;
        else                           eff_sp = setpoint;
    end
endmodule

// File: rtl/spd_ramp_core.sv
// Ramp accumulator: on each tick moves a fixed-point value toward the target by
// the up or down step and lands exactly on the target.
// Assumes RATE_W <= W + FRAC.
module spd_ramp_core
    import spd_ramp_pkg::*;
#(
    parameter int W      = 12,
    parameter int FRAC   = 8,
    parameter int RATE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [W-1:0]      tgt,
    input  logic [RATE_W-1:0] up_step,
    input  logic [RATE_W-1:0] dn_step,
    output logic [W-1:0]      ref_int,
    output logic              frac_zero
);
    localparam int ACC_W = W + FRAC;
    localparam int SUM_W = ACC_W + 1;

    logic [ACC_W-1:0] acc, acc_nx, tgt_full;
    logic [SUM_W-1:0] up_sum, dn_diff;
    ramp_dir_e        dir;

    assign tgt_full = {tgt, {FRAC{1'b0}}};
    assign up_sum   = {1'b0, acc} + SUM_W'(up_step);
    assign dn_diff  = {1'b0, acc} - SUM_W'(dn_step);

    // Direction from the full-precision comparison only.
    always_comb begin
        if (acc < tgt_full)      dir = RAMP_UP;
        else if (acc > tgt_full) dir = RAMP_DOWN;
        else                     dir = RAMP_HOLD;
    end

    // Next value with saturation on the target.
    always_comb begin
        acc_nx = acc;
        case (dir)
            RAMP_UP:   acc_nx = (up_sum >= {1'b0, tgt_full}) ? tgt_full : up_sum[ACC_W-1:0];
            RAMP_DOWN: acc_nx = (dn_diff[ACC_W] || dn_diff[ACC_W-1:0] <= tgt_full)
                                ? tgt_full : dn_diff[ACC_W-1:0];
            default:   acc_nx = acc;
        endcase
    end

    // Accumulator register, advanced only on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc <= '0;
        else if (tick) acc <= acc_nx;
    end

    assign ref_int   = acc[ACC_W-1:FRAC];
    assign frac_zero = (acc[FRAC-1:0] == '0);
endmodule

// File: rtl/spd_ramp_limiter.sv
// Speed reference ramp limiter top: conditions the setpoint, applies the
// current-limit override and drives the rate-limited accumulator.
// Assumes all inputs are synchronous to clk.
module spd_ramp_limiter #(
    parameter int W      = 12,
    parameter int FRAC   = 8,
    parameter int RATE_W = 12,
    parameter int PRE_W  = 20,
    parameter int FLOOR  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      setpoint,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic [RATE_W-1:0] accel_step,
    input  logic [RATE_W-1:0] decel_step,
    input  logic [PRE_W-1:0]  tick_div,
    input  logic              ilim_req,
    output logic [W-1:0]      ref_out,
    output logic              at_target
);
    logic         tick_w, run_latched, frac_zero_w;
    logic [W-1:0] eff_sp_w, tgt_w;

    spd_ramp_tick #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(tick_div), .tick(tick_w)
    );

    spd_ramp_setpt #(.W(W), .FLOOR(FLOOR)) u_setpt (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .setpoint(setpoint), .run_q(run_latched), .eff_sp(eff_sp_w)
    );

    // Current limit overrides the target with zero.
    assign tgt_w = ilim_req ? '0 : eff_sp_w;

    spd_ramp_core #(.W(W), .FRAC(FRAC), .RATE_W(RATE_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .tgt(tgt_w),
        .up_step(accel_step), .dn_step(decel_step),
        .ref_int(ref_out), .frac_zero(frac_zero_w)
    );

    // On-target flag against the effective setpoint.
    assign at_target = frac_zero_w && (ref_out == eff_sp_w);
endmodule

// File: rtl/spd_ramp_checker.sv
// Property checker for the ramp limiter, bound to the top module.
module spd_ramp_checker #(
    parameter int W      = 12,
    parameter int FRAC   = 8,
    parameter int RATE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [W-1:0]      ref_out,
    input logic [RATE_W-1:0] accel_step,
    input logic [RATE_W-1:0] decel_step,
    input logic              ilim_req,
    input logic              tick,
    input logic              run_q,
    input logic [W-1:0]      tgt
);
    logic [W:0] up_lim, dn_lim, ref_x;

    // Per-cycle movement bounds derived from the step inputs.
    always_comb begin
        up_lim = (W+1)'(accel_step >> FRAC) + 1'b1;
        dn_lim = (W+1)'(decel_step >> FRAC) + 1'b1;
        ref_x  = {1'b0, ref_out};
    end

    // R1: first cycle out of reset shows a zero reference.
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ref_out == '0);

    // R4: bounded rise per cycle.
    a_r4_rise_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_out > $past(ref_out)) |-> (ref_x - {1'b0, $past(ref_out)}) <= $past(up_lim));

    // R5: bounded fall per cycle.
    a_r5_fall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_out < $past(ref_out)) |-> ({1'b0, $past(ref_out)} - ref_x) <= $past(dn_lim));

    // R6: no overshoot while approaching from below or above.
    a_r6_no_overshoot_up: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ref_out) <= $past(tgt)) |-> ref_out <= $past(tgt));
    a_r6_no_overshoot_dn: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ref_out) > $past(tgt)) |-> ref_out >= $past(tgt));

    // R8: the output holds between ticks.
    a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(ref_out));

    // R9: current limit never lets the reference rise.
    a_r9_ilim_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ilim_req) |-> ref_out <= $past(ref_out));

    // R2: while stopped the reference never rises.
    a_r2_idle_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_q) |-> ref_out <= $past(ref_out));
endmodule

bind spd_ramp_limiter spd_ramp_checker #(.W(W), .FRAC(FRAC), .RATE_W(RATE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_out(ref_out), .accel_step(accel_step),
    .decel_step(decel_step), .ilim_req(ilim_req), .tick(tick_w),
    .run_q(run_latched), .tgt(tgt_w)
);

// File: tb/spd_ramp_limiter_test.sv
module spd_ramp_limiter_test;
    localparam int W = 12, FRAC = 8, RATE_W = 12, PRE_W = 20, FLOOR = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [W-1:0]      setpoint = '0;
    logic              start_req = 1'b0, stop_req = 1'b0, ilim_req = 1'b0;
    logic [RATE_W-1:0] accel_step = 12'd512, decel_step = 12'd512;
    logic [PRE_W-1:0]  tick_div = '0;
    logic [W-1:0]      ref_out;
    logic              at_target;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int w_cycles, w_changes;
    bit w_smooth, w_landed;

    spd_ramp_limiter #(.W(W), .FRAC(FRAC), .RATE_W(RATE_W), .PRE_W(PRE_W), .FLOOR(FLOOR)) uut (
        .clk(clk), .rst_n(rst_n), .setpoint(setpoint), .start_req(start_req),
        .stop_req(stop_req), .accel_step(accel_step), .decel_step(decel_step),
        .tick_div(tick_div), .ilim_req(ilim_req), .ref_out(ref_out), .at_target(at_target)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive_edge();
        @(posedge clk); #1;
    endtask

    task automatic pulse_start();
        drive_edge(); start_req = 1'b1;
        drive_edge(); start_req = 1'b0;
    endtask

    task automatic pulse_stop();
        drive_edge(); stop_req = 1'b1;
        drive_edge(); stop_req = 1'b0;
    endtask

    // Follow the output each cycle until it sits on tgt with at_target.
    task automatic watch(input int tgt, input int max_up, input int max_dn);
        int prev;
        @(negedge clk);
        prev = int'(ref_out);
        w_cycles = 0; w_changes = 0; w_smooth = 1'b1; w_landed = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            w_cycles++;
            if (int'(ref_out) != prev) w_changes++;
            if (int'(ref_out) - prev > max_up || prev - int'(ref_out) > max_dn) w_smooth = 1'b0;
            if (prev <= tgt && int'(ref_out) > tgt) w_smooth = 1'b0;
            if (prev >= tgt && int'(ref_out) < tgt) w_smooth = 1'b0;
            prev = int'(ref_out);
            if (int'(ref_out) == tgt && at_target) begin
                w_landed = 1'b1;
                break;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(ref_out == 0, "R1 reset ref_out", int'(ref_out), 0);
        chk(at_target == 1'b1, "R10 at_target at zero when stopped", int'(at_target), 1);
    endtask

    task automatic t_idle();
        bit moved = 1'b0;
        setpoint = 12'd200;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ref_out != 0) moved = 1'b1;
        end
        chk(!moved, "R2 ignored setpoint before start", int'(ref_out), 0);
    endtask

    task automatic t_floor();
        drive_edge(); setpoint = 12'd0;
        pulse_start();
        watch(FLOOR, 2, 2);
        chk(w_landed, "R3 floor reached at zero setting", int'(ref_out), FLOOR);
    endtask

    task automatic t_rise();
        drive_edge(); setpoint = 12'd100;
        watch(100, 2, 0);
        chk(w_landed && w_smooth, "R4 smooth rise to 100", int'(ref_out), 100);
        chk(w_cycles >= 46 && w_cycles <= 51, "R7 rise time 48 ticks", w_cycles, 48);
    endtask

    task automatic t_fall();
        drive_edge(); decel_step = 12'd128; setpoint = 12'd60;
        watch(60, 0, 1);
        chk(w_landed && w_smooth, "R5 smooth fractional fall to 60", int'(ref_out), 60);
        chk(w_cycles >= 78 && w_cycles <= 83, "R5 fall time 80 ticks", w_cycles, 80);
    endtask

    task automatic t_odd_step();
        drive_edge(); accel_step = 12'd768; setpoint = 12'd100;
        watch(100, 3, 0);
        chk(w_landed && w_smooth, "R6 exact landing, non-multiple distance", int'(ref_out), 100);
        chk(w_cycles >= 13 && w_cycles <= 16, "R6 landing time 14 ticks", w_cycles, 14);
    endtask

    task automatic t_prescale();
        drive_edge(); tick_div = 20'd3; accel_step = 12'd256; setpoint = 12'd120;
        watch(120, 1, 0);
        chk(w_landed, "R8 prescaled ramp lands on 120", int'(ref_out), 120);
        chk(w_cycles >= 76 && w_cycles <= 86, "R8 time for 20 ticks of 4 cycles", w_cycles, 80);
        chk(w_changes <= (w_cycles + 3) / 4 + 1, "R8 changes only on ticks", w_changes, 20);
        drive_edge(); tick_div = '0;
    endtask

    task automatic t_ilim();
        bit rose = 1'b0;
        int prev;
        drive_edge(); decel_step = 12'd256; setpoint = 12'd200; ilim_req = 1'b1;
        @(negedge clk); prev = int'(ref_out);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (int'(ref_out) > prev) rose = 1'b1;
            prev = int'(ref_out);
        end
        chk(!rose, "R9 no rise under current limit", prev, 120);
        chk(prev <= 95 && prev >= 85, "R9 fell at decel rate", prev, 90);
        chk(at_target == 1'b0, "R10 at_target low off setpoint", int'(at_target), 0);
        drive_edge(); ilim_req = 1'b0;
        watch(200, 1, 0);
        chk(w_landed && w_smooth, "R9 resumes to setpoint after flag clears", int'(ref_out), 200);
    endtask

    task automatic t_stop();
        bit moved = 1'b0;
        drive_edge(); decel_step = 12'd512;
        pulse_stop();
        watch(0, 0, 2);
        chk(w_landed && w_smooth, "R2 ramp to zero after stop", int'(ref_out), 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ref_out != 0) moved = 1'b1;
        end
        chk(!moved, "R2 stays zero while stopped", int'(ref_out), 0);
    endtask

    task automatic t_stop_wins();
        bit moved = 1'b0;
        drive_edge(); start_req = 1'b1; stop_req = 1'b1;
        drive_edge(); start_req = 1'b0; stop_req = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ref_out != 0) moved = 1'b1;
        end
        chk(!moved, "R2 stop dominates simultaneous start", int'(ref_out), 0);
    endtask

    task automatic t_reset_mid();
        pulse_start();
        repeat (10) @(negedge clk);
        drive_edge(); rst_n = 1'b0;
        drive_edge(); rst_n = 1'b1;
        @(negedge clk);
        chk(ref_out == 0, "R1 reset mid-ramp clears output", int'(ref_out), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_idle();
        t_floor();
        t_rise();
        t_fall();
        t_odd_step();
        t_prescale();
        t_ilim();
        t_stop();
        t_stop_wins();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule